// File: doc/BRIEF.md
# Timestamped Event Lane Distributor

This block sits between an event producer (a processor or DMA engine) and a set of per-lane event FIFOs. Each incoming event carries a timestamp and a payload. The block steers each event into one lane, so that every lane only ever receives events in time order. The FIFOs and the logic that plays events out stay outside the block. Each FIFO reports whether it can take another entry through a per-lane writable flag.

The block tracks a current lane. It moves to the following lane only when it must: the event goes back in time relative to that lane, or a pending spread request is present. A spread request becomes pending when the current lane's writable flag rises. The producer stalls after a write until the current lane is writable again, so a rising writable flag means that the lane just filled. Spreading can be switched off, which leaves only the switching that time order requires. Events that come too late for the present time counter are refused, and so are events aimed at a full lane. The outcome of each write is shown in a small status word that reads zero when all is well.

Top module: `evt_lane_router`

## Requirements
- R1: The current lane changes only from n to n+1, and from LANES-1 it wraps to 0.
- R2: With spreading disabled and every lane writable, writes with strictly increasing timestamps all land in the same lane.
- R3: A write whose timestamp is less than or equal to the last timestamp accepted into the current lane goes to the next lane.
- R4: With spread_en high, a rising edge of the current lane's writable flag sets a pending spread request. The next accepted write goes to the next lane and clears the request.
- R5: If a write consumes a pending request in the same cycle that the current lane's writable flag rises, the request stays set for the write after it.
- R6: With spread_en low, no request is set and any pending request is cleared, so the lane does not change.
- R7: A write with timestamp <= now_cnt + MARGIN (now_cnt as sampled in the write cycle) is dropped. It sets status bit 0 and leaves the lane and any pending request unchanged.
- R8: A write that is not late but whose target lane is not writable is dropped. It sets status bit 1 and leaves the lane unchanged.
- R9: One cycle after an accepted write, fifo_we has exactly the target lane's bit set, fifo_ts and fifo_data carry the event, and status reads 0. With no write, fifo_we is 0.
- R10: After reset the current lane is 0, no request is pending, status is 0 and fifo_we is 0.

Status is updated on every strobe and holds its value between strobes. Bit 0 means late, bit 1 means lane full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spread_en | input | 1 | Enables spread requests |
| now_cnt | input | TS_W | Present time counter |
| wr_stb | input | 1 | Event write strobe |
| wr_ts | input | TS_W | Event timestamp |
| wr_data | input | DATA_W | Event payload |
| lane_writable | input | LANES | Per-lane FIFO can accept an entry |
| fifo_we | output | LANES | Per-lane FIFO write enable |
| fifo_ts | output | TS_W | Timestamp to the FIFOs |
| fifo_data | output | DATA_W | Payload to the FIFOs |
| cur_lane | output | $clog2(LANES) | Current lane |
| status | output | 2 | bit0 late, bit1 lane full |

## Verification
A spread request can be consumed by a write in the same cycle that the current lane's writable flag rises again. The request logic has to clear and set the flag together. The bench provokes this by pulsing lane 0's writable flag to set a request, then dropping the flag and raising it again on the exact edge where the next write is strobed. It judges the result by the lane of that write (the next lane) and of the following write (one lane further). A second overlap, a late write refused while a request is pending, is judged by the request still moving the next good write on.

// File: rtl/evt_lane_router.sv
module evt_lane_router #(
  parameter int LANES  = 8,
  parameter int TS_W   = 32,
  parameter int DATA_W = 16,
  parameter int MARGIN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spread_en,
  input  logic [TS_W-1:0]          now_cnt,
  input  logic                     wr_stb,
  input  logic [TS_W-1:0]          wr_ts,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [LANES-1:0]         lane_writable,
  output logic [LANES-1:0]         fifo_we,
  output logic [TS_W-1:0]          fifo_ts,
  output logic [DATA_W-1:0]        fifo_data,
  output logic [$clog2(LANES)-1:0] cur_lane,
  output logic [1:0]               status
);
  localparam int LW = $clog2(LANES);

  logic [LANES-1:0] wr_q, lane_used;
  logic [TS_W-1:0]  last_ts [LANES];
  logic             spread_q;

  logic          rise, late, back, hop, full, accept;
  logic [LW-1:0] nxt, tgt;

  assign rise   = lane_writable[cur_lane] & ~wr_q[cur_lane];
  assign late   = {1'b0, wr_ts} <= ({1'b0, now_cnt} + (TS_W+1)'(MARGIN));
  assign back   = lane_used[cur_lane] & (wr_ts <= last_ts[cur_lane]);
  assign hop    = back | (spread_q & spread_en);
  assign nxt    = (cur_lane == LW'(LANES-1)) ? '0 : cur_lane + LW'(1);
  assign tgt    = hop ? nxt : cur_lane;
  assign full   = ~lane_writable[tgt];
  assign accept = wr_stb & ~late & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q      <= '1;
      lane_used <= '0;
      spread_q  <= 1'b0;
      cur_lane  <= '0;
      status    <= '0;
      fifo_we   <= '0;
      fifo_ts   <= '0;
      fifo_data <= '0;
      for (int i = 0; i < LANES; i++) last_ts[i] <= '0;
    end else begin
      wr_q    <= lane_writable;
      fifo_we <= '0;
      if (!spread_en)  spread_q <= 1'b0;
      else if (rise)   spread_q <= 1'b1;
      else if (accept) spread_q <= 1'b0;
      if (wr_stb) status <= {~late & full, late};
      if (accept) begin
        fifo_we        <= LANES'(1) << tgt;
        fifo_ts        <= wr_ts;
        fifo_data      <= wr_data;
        cur_lane       <= tgt;
        last_ts[tgt]   <= wr_ts;
        lane_used[tgt] <= 1'b1;
      end
    end
  end
endmodule

module evt_lane_router_chk #(
  parameter int LANES  = 8,
  parameter int TS_W   = 32,
  parameter int MARGIN = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_stb,
  input logic [TS_W-1:0]          wr_ts,
  input logic [TS_W-1:0]          now_cnt,
  input logic [LANES-1:0]         fifo_we,
  input logic [1:0]               status,
  input logic [$clog2(LANES)-1:0] cur_lane
);
  localparam int LW = $clog2(LANES);

  // R1
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lane != $past(cur_lane)) |->
    (cur_lane == (($past(cur_lane) == LW'(LANES-1)) ? LW'(0) : LW'($past(cur_lane) + LW'(1)))));

  // R9
  one_we_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fifo_we));

  // R9
  we_on_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we != '0) |-> fifo_we[cur_lane]);

  // R9
  idle_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> (fifo_we == '0));

  // R7
  late_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ({1'b0, wr_ts} <= ({1'b0, now_cnt} + (TS_W+1)'(MARGIN))))
    |=> (fifo_we == '0) && status[0] && $stable(cur_lane));
endmodule

bind evt_lane_router evt_lane_router_chk #(.LANES(LANES), .TS_W(TS_W), .MARGIN(MARGIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ts(wr_ts), .now_cnt(now_cnt),
  .fifo_we(fifo_we), .status(status), .cur_lane(cur_lane)
);

// File: tb/evt_lane_router_tb.sv
`timescale 1ns/1ps
module evt_lane_router_tb;
  localparam int LANES = 8, TS_W = 32, DATA_W = 16, MARGIN = 4;

  logic clk = 0, rst_n = 0, spread_en = 0, wr_stb = 0;
  logic [TS_W-1:0] now_cnt = 100, wr_ts = 0;
  logic [DATA_W-1:0] wr_data = 0;
  logic [LANES-1:0] lane_writable = '1;
  logic [LANES-1:0] fifo_we;
  logic [TS_W-1:0] fifo_ts;
  logic [DATA_W-1:0] fifo_data;
  logic [2:0] cur_lane;
  logic [1:0] status;

  int total = 0, bad = 0;
  bit seen = 0, done = 0;
  int q_lane[$], q_stat[$], q_ts[$], q_dat[$];
  string q_tag[$];

  always #4 clk = ~clk;

  evt_lane_router #(.LANES(LANES), .TS_W(TS_W), .DATA_W(DATA_W), .MARGIN(MARGIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .now_cnt(now_cnt),
    .wr_stb(wr_stb), .wr_ts(wr_ts), .wr_data(wr_data), .lane_writable(lane_writable),
    .fifo_we(fifo_we), .fifo_ts(fifo_ts), .fifo_data(fifo_data),
    .cur_lane(cur_lane), .status(status));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int ts, input int lane, input int stat, input string tag, input int lift = -1);
    @(negedge clk);
    if (lift >= 0) lane_writable[lift] = 1'b1;
    wr_stb = 1; wr_ts = ts; wr_data = DATA_W'(ts * 3);
    q_lane.push_back(lane); q_stat.push_back(stat); q_ts.push_back(ts);
    q_dat.push_back(ts * 3); q_tag.push_back(tag);
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic pulse(input int l);
    @(negedge clk); lane_writable[l] = 1'b0;
    @(negedge clk); lane_writable[l] = 1'b1;
  endtask

  always @(posedge clk) seen <= wr_stb;

  always @(negedge clk) if (seen && q_lane.size() > 0) begin
    int el, es, et, ed; string tg;
    logic [LANES-1:0] ew;
    el = q_lane.pop_front(); es = q_stat.pop_front(); et = q_ts.pop_front();
    ed = q_dat.pop_front(); tg = q_tag.pop_front();
    ew = (es == 0) ? (LANES'(1) << el) : '0;
    check(int'(cur_lane) == el, {tg, " lane"}, cur_lane, el);
    check(int'(status) == es, {tg, " status"}, status, es);
    check(fifo_we == ew, {tg, " fifo_we"}, fifo_we, ew);
    if (es == 0) begin
      check(int'(fifo_ts) == et, {tg, " ts R9"}, fifo_ts, et);
      check(int'(fifo_data) == (ed & 16'hffff), {tg, " data R9"}, fifo_data, ed & 16'hffff);
    end
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cur_lane == 0, "R10 lane", cur_lane, 0);
    check(status == 0, "R10 status", status, 0);
    check(fifo_we == 0, "R10 fifo_we", fifo_we, 0);
    // increasing timestamps, spread off
    wr(200, 0, 0, "R2 w1");
    wr(210, 0, 0, "R2 w2");
    wr(220, 0, 0, "R2 w3");
    // going back in time
    wr(215, 1, 0, "R3 back");
    wr(216, 1, 0, "R3 stay");
    // late event
    wr(104, 1, 1, "R7 late");
    wr(300, 1, 0, "R7 after");
    // full lane
    lane_writable[1] = 1'b0;
    wr(310, 1, 2, "R8 full");
    lane_writable[1] = 1'b1;
    @(negedge clk); @(negedge clk);
    // spread request
    spread_en = 1;
    pulse(1);
    wr(320, 2, 0, "R4 hop");
    wr(330, 2, 0, "R4 cleared");
    // spread disabled: rise blocked
    spread_en = 0;
    pulse(2);
    wr(340, 2, 0, "R6 blocked");
    // request set, then disabled, then re-enabled
    spread_en = 1;
    pulse(2);
    @(negedge clk); spread_en = 0;
    @(negedge clk); spread_en = 1;
    wr(350, 2, 0, "R6 cleared");
    // wrap by going back in time
    wr(345, 3, 0, "R1 l3");
    wr(344, 4, 0, "R1 l4");
    wr(343, 5, 0, "R1 l5");
    wr(342, 6, 0, "R1 l6");
    wr(341, 7, 0, "R1 l7");
    wr(340, 0, 0, "R1 wrap");
    // collision: consume request while current lane rises
    pulse(0);
    @(negedge clk); lane_writable[0] = 1'b0;
    wr(400, 1, 0, "R5 consume", 0);
    wr(410, 2, 0, "R5 kept");
    wr(420, 2, 0, "R5 cleared");
    // late write with request pending
    pulse(2);
    wr(50, 2, 1, "R7 late pending");
    wr(430, 3, 0, "R7 request kept");
    wr(440, 3, 0, "R4 after");
    repeat (3) @(negedge clk);
    check(q_lane.size() == 0, "R9 drained", q_lane.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule